// File: doc/BRIEF.md
# Multi-mode uplink frame assembler

This block builds one 120-bit uplink frame in each frame period. The frame carries a 4-bit header, 2 internal-control bits, 2 external-control bits and a payload. The payload comes from up to seven port-group slices, and each slice is 20 bits wide on the input bus. A single-cycle `frame_tick`, asserted once per frame period, marks each frame boundary. On that cycle the block captures every input: the mode, the header, both control fields, all slices and the 32 supplied check bits. The frame built from that capture leaves on the next boundary, together with a one-cycle `frame_valid` strobe.

The block has three payload layouts. In protected mode, five 16-bit groups sit above a 32-bit check field that is computed elsewhere. In wide mode the check field carries two more 16-bit groups. In line-coded mode, five groups of 20 already-encoded bits and half of a sixth group (10 bits) fill the payload. The error-correction coder and the 8b/10b encoder are outside this block.

Top module: `ulfa_top`

## Requirements
- R1: While reset is held, and on the first cycle after it, `frame_out` is all zeros and `frame_valid` is low.
- R2: The inputs are sampled only on cycles where `frame_tick` is high. The frame built from one capture appears on `frame_out` one cycle after the next `frame_tick`, and `frame_valid` is high for exactly that cycle. Between ticks, `frame_out` does not change.
- R3: The first `frame_tick` after reset has no captured frame behind it. It raises no `frame_valid` and leaves `frame_out` unchanged.
- R4: In every mode, `frame_out[119:116]` holds the header and `frame_out[115:114]` holds the internal-control bits. In modes 0, 1 and 3, `frame_out[113:112]` holds the external-control bits.
- R5: Mode 0 (protected) places bits [15:0] of slices 0 to 4 at `frame_out` [47:32], [63:48], [79:64], [95:80] and [111:96]. The 32 check bits go to [31:0].
- R6: Mode 1 (wide) places slices 0 to 4 as in R5. Bits [15:0] of slice 5 go to [15:0], bits [15:0] of slice 6 go to [31:16], and the check bits are ignored.
- R7: Mode 2 (line-coded) places all 20 bits of slices 0 to 4 at [19:0], [39:20], [59:40], [79:60] and [99:80]. Bits [9:0] of slice 5 go to [109:100]. Bits [113:110] are zero, and the external-control bits, the check bits and slice 6 are ignored.
- R8: Mode 3 builds the same frame as mode 0.
- R9: Slice bits that the mode's layout does not use have no effect on the frame. These are bits [19:16] of every slice in modes 0, 1 and 3, and slices 5 and 6 in mode 0.
- R10: A change of mode or data between two ticks has no effect until the next tick. The mode captured with a frame governs that whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame-logic clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_tick | input | 1 | One-cycle frame boundary strobe |
| mode_sel | input | 2 | 0 protected, 1 wide, 2 line-coded, 3 same as protected |
| header_cfg | input | 4 | Frame header value |
| ic_bits | input | 2 | Internal-control field |
| ec_bits | input | 2 | External-control field |
| grp_slices | input | 140 | Seven 20-bit group slices, slice g at [20g+19:20g] |
| check_bits | input | 32 | Externally computed check field |
| frame_out | output | 120 | Assembled frame |
| frame_valid | output | 1 | High for one cycle when a new frame is presented |

## Verification
The assertions are evaluated on every cycle. They check that the output holds between ticks, that the valid strobe follows only a tick, and that no strobe follows a tick with an empty capture. They also check that the header and the protected-mode check bits land where R4 and R5 place them, and that the upper control bits are zero after a line-coded frame. The bench scenarios are needed to show the full group-to-bit-range map of each mode, and that unused slice bits and the check field are ignored. They also show that mode 3 aliases protected mode and that changes between ticks wait for the next boundary.

// File: rtl/ulfa_pkg.sv
package ulfa_pkg;
  localparam int FRAME_W  = 120;
  localparam int HDR_W    = 4;
  localparam int CTL_W    = 2;
  localparam int CHK_W    = 32;
  localparam int SLICE_W  = 20;
  localparam int NARROW_W = 16;
  localparam int NUM_GRP  = 7;
  localparam int MAIN_GRP = 5;
  localparam int HALF_W   = SLICE_W / 2;
  localparam int SLICES_W = NUM_GRP * SLICE_W;
  localparam int NARROW_BASE = CHK_W;
  localparam int HDR_LSB  = FRAME_W - HDR_W;
  localparam int IC_LSB   = HDR_LSB - CTL_W;
  localparam int EC_LSB   = IC_LSB - CTL_W;
  localparam int HALF_LSB = MAIN_GRP * SLICE_W;

  typedef enum logic [1:0] {
    UL_PROT = 2'b00,
    UL_WIDE = 2'b01,
    UL_LINE = 2'b10,
    UL_RSVD = 2'b11
  } ul_mode_e;

  typedef struct packed {
    ul_mode_e              mode;
    logic [HDR_W-1:0]      hdr;
    logic [CTL_W-1:0]      ic;
    logic [CTL_W-1:0]      ec;
    logic [SLICES_W-1:0]   slices;
    logic [CHK_W-1:0]      check;
  } ul_stage_t;
endpackage

// File: rtl/ulfa_rst_sync.sv
module ulfa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ulfa_capture.sv
module ulfa_capture
  import ulfa_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [1:0]           mode_in,
  input  logic [HDR_W-1:0]     hdr_in,
  input  logic [CTL_W-1:0]     ic_in,
  input  logic [CTL_W-1:0]     ec_in,
  input  logic [SLICES_W-1:0]  slices_in,
  input  logic [CHK_W-1:0]     check_in,
  output ul_stage_t            stage,
  output logic                 stage_full
);
  ul_stage_t stage_d;
  logic      full_d;

  always_comb begin
    stage_d = stage;
    full_d  = stage_full;
    if (tick) begin
      stage_d.mode   = ul_mode_e'(mode_in);
      stage_d.hdr    = hdr_in;
      stage_d.ic     = ic_in;
      stage_d.ec     = ec_in;
      stage_d.slices = slices_in;
      stage_d.check  = check_in;
      full_d         = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage      <= '0;
      stage_full <= 1'b0;
    end else begin
      stage      <= stage_d;
      stage_full <= full_d;
    end
  end

  // R2: every tick leaves a frame waiting in the stage
  a_r2_capture_fills: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> stage_full);
endmodule

// File: rtl/ulfa_mapper.sv
module ulfa_mapper
  import ulfa_pkg::*;
(
  input  ul_stage_t             stage,
  output logic [FRAME_W-1:0]    frame
);
  logic [MAIN_GRP*NARROW_W-1:0] narrow_fld;
  logic [MAIN_GRP*SLICE_W-1:0]  coded_fld;

  for (genvar g = 0; g < MAIN_GRP; g++) begin : g_lane
    assign narrow_fld[g*NARROW_W +: NARROW_W] = stage.slices[g*SLICE_W +: NARROW_W];
    assign coded_fld[g*SLICE_W +: SLICE_W]    = stage.slices[g*SLICE_W +: SLICE_W];
  end

  always_comb begin
    frame = '0;
    frame[HDR_LSB +: HDR_W] = stage.hdr;
    frame[IC_LSB +: CTL_W]  = stage.ic;
    unique case (stage.mode)
      UL_LINE: begin
        frame[0 +: MAIN_GRP*SLICE_W] = coded_fld;
        frame[HALF_LSB +: HALF_W]    = stage.slices[MAIN_GRP*SLICE_W +: HALF_W];
      end
      UL_WIDE: begin
        frame[EC_LSB +: CTL_W] = stage.ec;
        frame[NARROW_BASE +: MAIN_GRP*NARROW_W] = narrow_fld;
        frame[0 +: NARROW_W]        = stage.slices[5*SLICE_W +: NARROW_W];
        frame[NARROW_W +: NARROW_W] = stage.slices[6*SLICE_W +: NARROW_W];
      end
      default: begin
        frame[EC_LSB +: CTL_W] = stage.ec;
        frame[NARROW_BASE +: MAIN_GRP*NARROW_W] = narrow_fld;
        frame[0 +: CHK_W] = stage.check;
      end
    endcase
  end
endmodule

// File: rtl/ulfa_top.sv
module ulfa_top
  import ulfa_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_tick,
  input  logic [1:0]           mode_sel,
  input  logic [HDR_W-1:0]     header_cfg,
  input  logic [CTL_W-1:0]     ic_bits,
  input  logic [CTL_W-1:0]     ec_bits,
  input  logic [SLICES_W-1:0]  grp_slices,
  input  logic [CHK_W-1:0]     check_bits,
  output logic [FRAME_W-1:0]   frame_out,
  output logic                 frame_valid
);
  logic                rst_sync_n;
  ul_stage_t           stage;
  logic                stage_full;
  logic [FRAME_W-1:0]  mapped;
  logic [FRAME_W-1:0]  frame_d;
  logic                valid_d;

  ulfa_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ulfa_capture cap_i (
    .clk(clk), .rst_n(rst_sync_n), .tick(frame_tick), .mode_in(mode_sel),
    .hdr_in(header_cfg), .ic_in(ic_bits), .ec_in(ec_bits),
    .slices_in(grp_slices), .check_in(check_bits),
    .stage(stage), .stage_full(stage_full)
  );

  ulfa_mapper map_i (.stage(stage), .frame(mapped));

  always_comb begin
    frame_d = frame_out;
    valid_d = 1'b0;
    if (frame_tick && stage_full) begin
      frame_d = mapped;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      frame_out   <= '0;
      frame_valid <= 1'b0;
    end else begin
      frame_out   <= frame_d;
      frame_valid <= valid_d;
    end
  end

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !frame_tick |=> $stable(frame_out));

  a_r2_valid_follows_tick: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_valid |-> $past(frame_tick));

  a_r3_no_valid_when_empty: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_tick && !stage_full |=> !frame_valid && $stable(frame_out));

  a_r4_header_place: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_tick && stage_full |=> frame_out[HDR_LSB +: HDR_W] == $past(stage.hdr));

  a_r5_check_field: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_tick && stage_full && stage.mode == UL_PROT |=>
      frame_out[CHK_W-1:0] == $past(stage.check));

  a_r7_line_top_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_tick && stage_full && stage.mode == UL_LINE |=>
      frame_out[IC_LSB-1:HALF_LSB+HALF_W] == '0);
endmodule

// File: tb/ulfa_top_tb_top.sv
module ulfa_top_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         frame_tick;
  logic [1:0]   mode_sel;
  logic [3:0]   header_cfg;
  logic [1:0]   ic_bits;
  logic [1:0]   ec_bits;
  logic [139:0] grp_slices;
  logic [31:0]  check_bits;
  logic [119:0] frame_out;
  logic         frame_valid;

  int checks = 0;
  int errors = 0;
  logic [119:0] exp_prev;
  logic [119:0] exp_last;

  always #4 clk = ~clk;

  ulfa_top dut_i (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .mode_sel(mode_sel),
    .header_cfg(header_cfg), .ic_bits(ic_bits), .ec_bits(ec_bits),
    .grp_slices(grp_slices), .check_bits(check_bits),
    .frame_out(frame_out), .frame_valid(frame_valid)
  );

  function automatic logic [119:0] expect_frame(input logic [1:0] m, input logic [3:0] h,
      input logic [1:0] ic, input logic [1:0] ec, input logic [139:0] s, input logic [31:0] c);
    logic [119:0] f = '0;
    f[119:116] = h;
    f[115:114] = ic;
    if (m == 2'd2) begin
      for (int g = 0; g < 5; g++) f[g*20 +: 20] = s[g*20 +: 20];
      f[109:100] = s[100 +: 10];
    end else begin
      f[113:112] = ec;
      for (int g = 0; g < 5; g++) f[32 + g*16 +: 16] = s[g*20 +: 16];
      if (m == 2'd1) begin
        f[15:0]  = s[100 +: 16];
        f[31:16] = s[120 +: 16];
      end else f[31:0] = c;
    end
    return f;
  endfunction

  function automatic logic [139:0] pattern(input int seed);
    logic [139:0] s;
    for (int g = 0; g < 7; g++) s[g*20 +: 20] = 20'(32'hF0000 | ((seed * 32'h1F3 + g * 32'h2B7) & 32'hFFFF) | (g << 16));
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [119:0] act, input logic [119:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [1:0] m, input logic [3:0] h, input logic [1:0] ic,
      input logic [1:0] ec, input logic [139:0] s, input logic [31:0] c);
    @(negedge clk);
    mode_sel = m; header_cfg = h; ic_bits = ic; ec_bits = ec; grp_slices = s; check_bits = c;
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    exp_prev = exp_last;
    exp_last = expect_frame(m, h, ic, ec, s, c);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; frame_tick = 1'b0; mode_sel = 0; header_cfg = 0; ic_bits = 0;
    ec_bits = 0; grp_slices = '0; check_bits = 0;
    idle(3);
    check(frame_out == '0 && !frame_valid, "R1 in reset", frame_out, '0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(frame_out == '0 && !frame_valid, "R1 after release", frame_out, '0);
    idle(4);
  endtask

  task automatic t_first_tick;
    launch(2'd0, 4'h5, 2'b10, 2'b01, pattern(1), 32'hDEADBEEF);
    check(!frame_valid && frame_out == '0, "R3 first tick", frame_out, '0);
  endtask

  task automatic t_protected;
    idle(3);
    launch(2'd0, 4'hA, 2'b01, 2'b11, pattern(2), 32'h12345678);
    check(frame_valid && frame_out == exp_prev, "R5 R9 protected", frame_out, exp_prev);
    check(frame_out[119:112] == {4'h5, 2'b10, 2'b01}, "R4 header/ctl", frame_out, exp_prev);
    @(negedge clk);
    check(!frame_valid, "R2 valid one cycle", {119'b0, frame_valid}, '0);
  endtask

  task automatic t_wide;
    idle(2);
    launch(2'd1, 4'h3, 2'b11, 2'b10, pattern(3), 32'hCAFEF00D);
    check(frame_valid && frame_out == exp_prev, "R5 protected frame out", frame_out, exp_prev);
    idle(2);
    launch(2'd2, 4'hC, 2'b00, 2'b11, pattern(4), 32'h0BADC0DE);
    check(frame_valid && frame_out == exp_prev, "R6 R9 wide", frame_out, exp_prev);
  endtask

  task automatic t_line;
    idle(2);
    launch(2'd3, 4'h9, 2'b10, 2'b01, pattern(5), 32'h55AA55AA);
    check(frame_valid && frame_out == exp_prev, "R7 line-coded", frame_out, exp_prev);
    check(frame_out[113:110] == 4'h0, "R7 ec/top zero", frame_out, exp_prev);
  endtask

  task automatic t_reserved;
    logic [119:0] ref_f;
    ref_f = expect_frame(2'd0, 4'h9, 2'b10, 2'b01, pattern(5), 32'h55AA55AA);
    idle(2);
    launch(2'd0, 4'h1, 2'b01, 2'b10, pattern(6), 32'h01020304);
    check(frame_valid && frame_out == exp_prev && frame_out == ref_f, "R8 mode3 as protected", frame_out, ref_f);
  endtask

  task automatic t_between_ticks;
    logic [119:0] held;
    idle(1);
    held = frame_out;
    mode_sel = 2'd2; grp_slices = pattern(9); check_bits = 32'hFFFFFFFF; header_cfg = 4'hF;
    idle(4);
    check(frame_out == held && !frame_valid, "R10 no change between ticks", frame_out, held);
    launch(2'd1, 4'h7, 2'b00, 2'b00, pattern(7), 32'h0);
    check(frame_valid && frame_out == exp_prev, "R10 mode held for frame", frame_out, exp_prev);
    // R9: upper nibbles set and other slices only differ in unused bits
    launch(2'd0, 4'h2, 2'b01, 2'b01, pattern(7) ^ {20'hFFFFF, 20'hFFFFF, {5{20'hF0000}}}, 32'h0);
    check(frame_valid && frame_out == exp_prev, "R6 wide second", frame_out, exp_prev);
    launch(2'd0, 4'h2, 2'b01, 2'b01, pattern(7), 32'h0);
    check(frame_valid && frame_out == exp_prev && frame_out == exp_last, "R9 unused bits ignored", frame_out, exp_last);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_first_tick();
    t_protected();
    t_wide();
    t_line();
    t_reserved();
    t_between_ticks();
    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule